// File: doc/BRIEF.md
# Single-Channel Memory/I/O Byte Mover

This block is one DMA channel that moves bytes between a memory address and an I/O address, or between two memory addresses when the peer is mapped into memory space. Software loads a source address, a destination address, a per-side addressing mode, a byte count and a request-sense choice. It then starts the channel by writing the run bit together with a clear lock bit. Each byte takes two bus cycles. The first reads from the source and the second writes the captured byte to the destination.

The request that paces each byte comes from one of two places. The first is an active-low request pin, sensed either on its falling edge or as a level. The second is the status flags of an on-chip serial port: the transmit-empty flag when the port is the destination, and the receive-full flag when the port is the source. When the count is used up, the channel drops its run bit and marks the transfer done. It pulses the end-of-transfer output during the final write and, if enabled, raises its interrupt.

Top module: `dma_chan`

## Requirements
- R1: After reset, every register reads 0, and `irq`, `bus_req`, `xfer_end` and `pins_owned` are 0.
- R2: Register selects are 0 source address, 1 destination address, 2 byte count, 3 mode, 4 status. Mode bits: [1:0] source mode, [3:2] destination mode, [4] edge sense, [5] serial peer. Status bits on write: [0] interrupt enable, [1] run, [2] lock. Status bits on read: [0] interrupt enable, [1] run, [2] done. Every register reads back what was written.
- R3: A status write changes the run bit only when bit [2] of that write is 0. With the lock bit set, run keeps its old value in either direction. While run is 0, the channel starts no bus cycle.
- R4: Mode code 0 increments the address after each byte, 1 decrements it, 2 holds it, and 3 marks that side as I/O. An I/O side keeps its address fixed, drives only the low 16 address bits with bits 19:16 at zero, and raises `bus_io` during its cycle.
- R5: Each byte is a read of the source followed by a write of the same byte to the destination. `bus_req`, `bus_wr` and `bus_addr` hold steady until `bus_ack`.
- R6: In edge mode, each falling edge of `dreq_n` seen while running causes exactly one byte, however long the pin then stays low.
- R7: In level mode, bytes continue back to back while `dreq_n` is low.
- R8: With the external pin as the request, the pin is ignored when the I/O-side address has any of bits 16, 17 or 19 set. Bit 18 has no effect on this.
- R9: With the serial peer selected, `dreq_n` is ignored. The request is `tx_empty` when the destination is I/O and `rx_full` when the source is I/O.
- R10: The count drops by one per byte. On the final write acknowledge, `xfer_end` is high for that one cycle. After that, run is 0 and done is 1.
- R11: `irq` is high while done and interrupt enable are both 1. A successful start clears done.
- R12: A count of 0 moves 2^COUNT_W bytes.
- R13: `pins_owned` is high while running with at least one side in I/O mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 3 | Write register select |
| reg_wdata | input | 20 | Write data |
| reg_rsel | input | 3 | Read register select |
| reg_rdata | output | 20 | Read data (combinational) |
| dreq_n | input | 1 | External request, active low |
| tx_empty | input | 1 | Serial port transmit register empty |
| rx_full | input | 1 | Serial port receive register full |
| bus_req | output | 1 | Bus cycle request |
| bus_wr | output | 1 | 1 for write cycle, 0 for read |
| bus_io | output | 1 | Cycle is in I/O space |
| bus_addr | output | 20 | Cycle address |
| bus_wdata | output | 8 | Write data |
| bus_rdata | input | 8 | Read data, sampled on acknowledge |
| bus_ack | input | 1 | Cycle completes this clock |
| xfer_end | output | 1 | Final-byte marker |
| irq | output | 1 | Transfer-complete interrupt |
| pins_owned | output | 1 | Request and end pins claimed by the channel |

## Verification
The bound checker watches several rules on every cycle. It checks that a pending bus cycle holds its address and direction until acknowledged, and that I/O cycles keep address bits 19:16 clear. It checks that `xfer_end` falls only on an acknowledged write, after which run is gone, and that the count steps by exactly one per non-final byte. It also checks that no cycle starts while stopped and that the interrupt never coexists with run. The remaining behaviours need scenarios from the bench: the data and address sequence of each mode combination, one byte per edge against continuous level transfers, the address-bit gating of the pin, the serial flag selection, the lock bit, and the full-range count of zero.

// File: rtl/dma_pkg.sv
package dma_pkg;
  localparam int unsigned ADDR_W = 20;
  localparam int unsigned DATA_W = 8;

  localparam logic [ADDR_W-1:0] IO_KEEP_MASK = 20'h0FFFF;
  localparam logic [ADDR_W-1:0] EXT_GATE_MASK = 20'hB0000;

  localparam logic [2:0] SEL_SRC  = 3'd0;
  localparam logic [2:0] SEL_DST  = 3'd1;
  localparam logic [2:0] SEL_CNT  = 3'd2;
  localparam logic [2:0] SEL_MODE = 3'd3;
  localparam logic [2:0] SEL_STAT = 3'd4;

  typedef enum logic [1:0] {
    AM_INC = 2'b00,
    AM_DEC = 2'b01,
    AM_FIX = 2'b10,
    AM_IO  = 2'b11
  } addr_mode_e;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'b00,
    SQ_RD   = 2'b01,
    SQ_WR   = 2'b10
  } seq_state_e;

  function automatic logic [ADDR_W-1:0] next_addr(input logic [ADDR_W-1:0] a,
                                                  input addr_mode_e m);
    case (m)
      AM_INC:  next_addr = a + 1'b1;
      AM_DEC:  next_addr = a - 1'b1;
      default: next_addr = a;
    endcase
  endfunction

  function automatic logic [ADDR_W-1:0] bus_form(input logic [ADDR_W-1:0] a,
                                                 input addr_mode_e m);
    bus_form = (m == AM_IO) ? (a & IO_KEEP_MASK) : a;
  endfunction

  function automatic logic ext_gate_ok(input logic [ADDR_W-1:0] a);
    ext_gate_ok = ((a & EXT_GATE_MASK) == '0);
  endfunction
endpackage

// File: rtl/dma_regs.sv
module dma_regs
  import dma_pkg::*;
#(
  parameter int unsigned COUNT_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [2:0]         wr_sel,
  input  logic [ADDR_W-1:0]  wr_data,
  input  logic               byte_done,
  input  logic               last_done,
  output logic [ADDR_W-1:0]  src,
  output logic [ADDR_W-1:0]  dst,
  output logic [COUNT_W-1:0] count,
  output addr_mode_e         src_mode,
  output addr_mode_e         dst_mode,
  output logic               edge_mode,
  output logic               serial_peer,
  output logic               irq_en,
  output logic               run,
  output logic               done
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src         <= '0;
      dst         <= '0;
      count       <= '0;
      src_mode    <= AM_INC;
      dst_mode    <= AM_INC;
      edge_mode   <= 1'b0;
      serial_peer <= 1'b0;
      irq_en      <= 1'b0;
      run         <= 1'b0;
      done        <= 1'b0;
    end else begin
      if (wr_en) begin
        case (wr_sel)
          SEL_SRC: src <= wr_data;
          SEL_DST: dst <= wr_data;
          SEL_CNT: count <= wr_data[COUNT_W-1:0];
          SEL_MODE: begin
            src_mode    <= addr_mode_e'(wr_data[1:0]);
            dst_mode    <= addr_mode_e'(wr_data[3:2]);
            edge_mode   <= wr_data[4];
            serial_peer <= wr_data[5];
          end
          SEL_STAT: begin
            irq_en <= wr_data[0];
            if (!wr_data[2]) begin
              run <= wr_data[1];
              if (wr_data[1]) done <= 1'b0;
            end
          end
          default: ;
        endcase
      end
      // a finished byte outranks a same-cycle software write
      if (byte_done) begin
        src   <= next_addr(src, src_mode);
        dst   <= next_addr(dst, dst_mode);
        count <= count - 1'b1;
        if (last_done) begin
          run  <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/dma_req.sv
module dma_req
  import dma_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              edge_mode,
  input  logic              serial_peer,
  input  addr_mode_e        src_mode,
  input  addr_mode_e        dst_mode,
  input  logic [ADDR_W-1:0] src,
  input  logic [ADDR_W-1:0] dst,
  input  logic              dreq_n,
  input  logic              tx_empty,
  input  logic              rx_full,
  input  logic              take,
  output logic              req
);
  logic dreq_q, pend_q;
  logic src_io, dst_io, ext_ok, fall, serial_req, pin_req;
  logic [ADDR_W-1:0] io_side;

  assign src_io  = (src_mode == AM_IO);
  assign dst_io  = (dst_mode == AM_IO);
  assign io_side = dst_io ? dst : src;
  assign ext_ok  = !(src_io || dst_io) || ext_gate_ok(io_side);
  assign fall    = dreq_q && !dreq_n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dreq_q <= 1'b1;
      pend_q <= 1'b0;
    end else begin
      dreq_q <= dreq_n;
      if (!run)
        pend_q <= 1'b0;
      else begin
        if (take) pend_q <= 1'b0;
        if (fall && ext_ok) pend_q <= 1'b1;
      end
    end
  end

  assign serial_req = dst_io ? tx_empty : (src_io && rx_full);
  assign pin_req    = edge_mode ? pend_q : (!dreq_n && ext_ok);
  assign req        = serial_peer ? serial_req : pin_req;
endmodule

// File: rtl/dma_seq.sv
module dma_seq
  import dma_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              req,
  input  logic              last,
  input  logic [ADDR_W-1:0] src,
  input  logic [ADDR_W-1:0] dst,
  input  addr_mode_e        src_mode,
  input  addr_mode_e        dst_mode,
  input  logic              bus_ack,
  input  logic [DATA_W-1:0] bus_rdata,
  output logic              bus_req,
  output logic              bus_wr,
  output logic              bus_io,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  output logic              take,
  output logic              byte_done,
  output logic              xfer_end
);
  seq_state_e state_q;
  logic [DATA_W-1:0] data_q;

  assign take      = (state_q == SQ_IDLE) && run && req;
  assign byte_done = (state_q == SQ_WR) && bus_ack;
  assign xfer_end  = byte_done && last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      data_q  <= '0;
    end else begin
      case (state_q)
        SQ_IDLE: if (take) state_q <= SQ_RD;
        SQ_RD: if (bus_ack) begin
          data_q  <= bus_rdata;
          state_q <= SQ_WR;
        end
        SQ_WR: if (bus_ack) state_q <= SQ_IDLE;
        default: state_q <= SQ_IDLE;
      endcase
    end
  end

  always_comb begin
    bus_req  = 1'b0;
    bus_wr   = 1'b0;
    bus_io   = 1'b0;
    bus_addr = '0;
    case (state_q)
      SQ_RD: begin
        bus_req  = 1'b1;
        bus_io   = (src_mode == AM_IO);
        bus_addr = bus_form(src, src_mode);
      end
      SQ_WR: begin
        bus_req  = 1'b1;
        bus_wr   = 1'b1;
        bus_io   = (dst_mode == AM_IO);
        bus_addr = bus_form(dst, dst_mode);
      end
      default: ;
    endcase
  end

  assign bus_wdata = data_q;
endmodule

// File: rtl/dma_chan.sv
module dma_chan
  import dma_pkg::*;
#(
  parameter int unsigned COUNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [2:0]        reg_sel,
  input  logic [ADDR_W-1:0] reg_wdata,
  input  logic [2:0]        reg_rsel,
  output logic [ADDR_W-1:0] reg_rdata,
  input  logic              dreq_n,
  input  logic              tx_empty,
  input  logic              rx_full,
  output logic              bus_req,
  output logic              bus_wr,
  output logic              bus_io,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              bus_ack,
  output logic              xfer_end,
  output logic              irq,
  output logic              pins_owned
);
  localparam logic [COUNT_W-1:0] CNT_ONE = COUNT_W'(1);

  logic [ADDR_W-1:0]  src_q, dst_q;
  logic [COUNT_W-1:0] count_q;
  addr_mode_e         src_mode, dst_mode;
  logic edge_mode, serial_peer, irq_en, run_q, done_q;
  logic req, take, byte_done, last;

  assign last = (count_q == CNT_ONE);

  dma_regs #(.COUNT_W(COUNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en(reg_wr), .wr_sel(reg_sel), .wr_data(reg_wdata),
    .byte_done(byte_done), .last_done(xfer_end),
    .src(src_q), .dst(dst_q), .count(count_q),
    .src_mode(src_mode), .dst_mode(dst_mode),
    .edge_mode(edge_mode), .serial_peer(serial_peer),
    .irq_en(irq_en), .run(run_q), .done(done_q)
  );

  dma_req u_req (
    .clk(clk), .rst_n(rst_n), .run(run_q),
    .edge_mode(edge_mode), .serial_peer(serial_peer),
    .src_mode(src_mode), .dst_mode(dst_mode),
    .src(src_q), .dst(dst_q),
    .dreq_n(dreq_n), .tx_empty(tx_empty), .rx_full(rx_full),
    .take(take), .req(req)
  );

  dma_seq u_seq (
    .clk(clk), .rst_n(rst_n), .run(run_q), .req(req), .last(last),
    .src(src_q), .dst(dst_q), .src_mode(src_mode), .dst_mode(dst_mode),
    .bus_ack(bus_ack), .bus_rdata(bus_rdata),
    .bus_req(bus_req), .bus_wr(bus_wr), .bus_io(bus_io),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .take(take), .byte_done(byte_done), .xfer_end(xfer_end)
  );

  always_comb begin
    case (reg_rsel)
      SEL_SRC:  reg_rdata = src_q;
      SEL_DST:  reg_rdata = dst_q;
      SEL_CNT:  reg_rdata = ADDR_W'(count_q);
      SEL_MODE: reg_rdata = ADDR_W'({serial_peer, edge_mode, dst_mode, src_mode});
      SEL_STAT: reg_rdata = ADDR_W'({done_q, run_q, irq_en});
      default:  reg_rdata = '0;
    endcase
  end

  assign irq        = done_q && irq_en;
  assign pins_owned = run_q && ((src_mode == AM_IO) || (dst_mode == AM_IO));
endmodule

// File: rtl/dma_chan_sva.sv
module dma_chan_sva #(
  parameter int unsigned COUNT_W = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               bus_req,
  input logic               bus_wr,
  input logic               bus_ack,
  input logic               bus_io,
  input logic [19:0]        bus_addr,
  input logic               xfer_end,
  input logic               run,
  input logic [COUNT_W-1:0] count,
  input logic               byte_done,
  input logic               irq
);
  p_wr_inside_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr |-> bus_req);

  p_hold_until_ack_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr) && $stable(bus_wr)));

  p_io_upper_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_io) |-> ((bus_addr & 20'hF0000) == 20'h0));

  p_end_on_write_ack_r10: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_end |-> (bus_ack && bus_wr));

  p_run_drops_after_end_r10: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_end |=> !run);

  p_count_steps_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && !xfer_end) |=> (count == $past(count) - 1'b1));

  p_no_start_when_stopped_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !bus_req) |=> !bus_req);

  p_irq_not_while_running_r11: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> !run);
endmodule

bind dma_chan dma_chan_sva #(.COUNT_W(COUNT_W)) u_sva (
  .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_wr(bus_wr),
  .bus_ack(bus_ack), .bus_io(bus_io), .bus_addr(bus_addr),
  .xfer_end(xfer_end), .run(run_q), .count(count_q),
  .byte_done(byte_done), .irq(irq)
);

// File: tb/tb_dma_chan.sv
module tb_dma_chan;
  localparam int CW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [2:0] reg_sel = '0, reg_rsel = '0;
  logic [19:0] reg_wdata = '0, reg_rdata;
  logic dreq_n = 1'b1, tx_empty = 1'b0, rx_full = 1'b0;
  logic bus_req, bus_wr, bus_io, xfer_end, irq, pins_owned;
  logic [19:0] bus_addr;
  logic [7:0] bus_wdata, bus_rdata;
  logic bus_ack = 1'b0;

  int checks = 0, errors = 0;
  bit exp_on = 0;
  int wr_seen = 0, e_total = 0;
  logic [19:0] e_src, e_dst;
  logic [1:0] e_sm, e_dm;

  always #4 clk = ~clk;

  dma_chan #(.COUNT_W(CW)) dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rsel(reg_rsel), .reg_rdata(reg_rdata),
    .dreq_n(dreq_n), .tx_empty(tx_empty), .rx_full(rx_full),
    .bus_req(bus_req), .bus_wr(bus_wr), .bus_io(bus_io),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_ack(bus_ack), .xfer_end(xfer_end), .irq(irq), .pins_owned(pins_owned)
  );

  function automatic logic [7:0] mem_val(input logic [19:0] a);
    return a[7:0] ^ a[15:8] ^ {4'h0, a[19:16]} ^ 8'h5A;
  endfunction
  function automatic logic [19:0] b_step(input logic [19:0] a, input logic [1:0] m);
    if (m == 2'd0) return a + 20'd1;
    if (m == 2'd1) return a - 20'd1;
    return a;
  endfunction
  function automatic logic [19:0] b_bus(input logic [19:0] a, input logic [1:0] m);
    return (m == 2'd3) ? {4'h0, a[15:0]} : a;
  endfunction

  assign bus_rdata = mem_val(bus_addr);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // bus responder and per-cycle checker
  always @(negedge clk) begin
    if (bus_ack) bus_ack = 1'b0;
    else if (rst_n && bus_req && ($urandom % 3 != 0)) begin
      bus_ack = 1'b1;
      #1;
      if (!exp_on) chk("R8/R9 unexpected bus cycle", 1, 0);
      else if (!bus_wr) begin
        chk("R4 read address", bus_addr, b_bus(e_src, e_sm));
        chk("R4 read io flag", bus_io, (e_sm == 2'd3));
      end else begin
        chk("R4 write address", bus_addr, b_bus(e_dst, e_dm));
        chk("R4 write io flag", bus_io, (e_dm == 2'd3));
        chk("R5 write data", bus_wdata, mem_val(b_bus(e_src, e_sm)));
        chk("R10 end marker", xfer_end, (wr_seen + 1 == e_total));
        e_src = b_step(e_src, e_sm);
        e_dst = b_step(e_dst, e_dm);
        wr_seen++;
      end
    end
  end

  task automatic wreg(input logic [2:0] sel, input logic [19:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rreg(input logic [2:0] sel, output logic [19:0] d);
    reg_rsel = sel;
    #1;
    d = reg_rdata;
  endtask

  task automatic setup(input logic [19:0] s, input logic [19:0] d, input logic [1:0] sm,
                       input logic [1:0] dm, input int cnt, input bit ie,
                       input bit edg, input bit ser);
    e_src = s; e_dst = d; e_sm = sm; e_dm = dm;
    e_total = (cnt == 0) ? (1 << CW) : cnt;
    wr_seen = 0;
    wreg(3'd0, s);
    wreg(3'd1, d);
    wreg(3'd2, 20'(cnt));
    wreg(3'd3, {14'b0, ser, edg, dm, sm});
    exp_on = 1;
    wreg(3'd4, {17'b0, 1'b0, 1'b1, ie});
  endtask

  task automatic wait_done(input string tag);
    logic [19:0] v;
    for (int i = 0; i < 6000; i++) begin
      @(negedge clk);
      rreg(3'd4, v);
      if (!v[1]) break;
    end
    rreg(3'd4, v);
    chk({tag, " run cleared"}, v[1], 0);
    chk({tag, " done set"}, v[2], 1);
  endtask

  task automatic wait_bytes(input int n);
    for (int i = 0; i < 300; i++) begin
      if (wr_seen >= n) break;
      @(negedge clk);
    end
  endtask

  task automatic finish_chk(input string tag, input bit ie);
    logic [19:0] v;
    chk({tag, " R10 bytes moved"}, wr_seen, e_total);
    rreg(3'd2, v);
    chk({tag, " R10 count zero"}, v, 0);
    chk({tag, " R11 irq"}, irq, ie);
    chk({tag, " R13 pins released"}, pins_owned, 0);
    exp_on = 0;
  endtask

  task automatic edge_pulse(input int target);
    @(negedge clk); dreq_n = 1'b0;
    repeat (12) @(negedge clk);
    dreq_n = 1'b1;
    wait_bytes(target);
  endtask

  initial begin
    logic [19:0] v;
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog (all requirements): actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [19:0] v, s, d;
    logic [1:0] sm, dm;
    int cnt, k;
    bit ie;
    void'($urandom(32'd20240611));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int r = 0; r < 5; r++) begin
      rreg(3'(r), v);
      chk("R1 register reset", v, 0);
    end
    chk("R1 irq reset", irq, 0);
    chk("R1 bus_req reset", bus_req, 0);
    chk("R1 xfer_end reset", xfer_end, 0);
    chk("R1 pins_owned reset", pins_owned, 0);

    // R2 readback
    wreg(3'd0, 20'hA5C3E); rreg(3'd0, v); chk("R2 source readback", v, 20'hA5C3E);
    wreg(3'd1, 20'h13579); rreg(3'd1, v); chk("R2 destination readback", v, 20'h13579);
    wreg(3'd2, 20'h000C7); rreg(3'd2, v); chk("R2 count readback", v, 20'h000C7);
    wreg(3'd3, 20'h0003B); rreg(3'd3, v); chk("R2 mode readback", v, 20'h0003B);

    // R3 lock bit blocks start; pin held low in level mode moves nothing
    wreg(3'd3, 20'h0);
    dreq_n = 1'b0;
    wreg(3'd4, 20'h7);
    rreg(3'd4, v);
    chk("R3 locked start ignored", v[1], 0);
    chk("R2 irq enable written under lock", v[0], 1);
    repeat (20) @(negedge clk);
    chk("R3 no cycle while stopped", bus_req, 0);
    dreq_n = 1'b1;
    wreg(3'd4, 20'h0);

    // R7 level-mode random transfers; R4/R5 checked per byte
    for (int t = 0; t < 12; t++) begin
      k = $urandom % 3;
      s = 20'($urandom); d = 20'($urandom);
      sm = 2'($urandom % 3); dm = 2'($urandom % 3);
      if (k == 1) begin dm = 2'd3; d = d & 20'h4FFFF; end
      if (k == 2) begin sm = 2'd3; s = s & 20'h4FFFF; end
      cnt = 1 + ($urandom % 12);
      ie = 1'($urandom);
      setup(s, d, sm, dm, cnt, ie, 0, 0);
      @(negedge clk);
      chk("R13 pins owned", pins_owned, (k != 0));
      dreq_n = 1'b0;
      wait_done("R7 level");
      dreq_n = 1'b1;
      finish_chk("R7 level", ie);
    end

    // R6 edge mode: one byte per falling edge
    setup(20'h00100, 20'h00200, 2'd0, 2'd1, 4, 1, 1, 0);
    edge_pulse(1);
    edge_pulse(2);
    repeat (30) @(negedge clk);
    chk("R6 bytes after two edges", wr_seen, 2);
    rreg(3'd2, v);
    chk("R6 count after two edges", v, 2);
    chk("R11 no irq mid-transfer", irq, 0);
    edge_pulse(3);
    edge_pulse(4);
    wait_done("R6 edge");
    finish_chk("R6 edge", 1);
    // R11 restart clears done and irq
    wreg(3'd4, 20'h3);
    chk("R11 restart clears irq", irq, 0);
    wreg(3'd4, 20'h5);
    rreg(3'd4, v);
    chk("R3 locked stop ignored", v[1], 1);
    wreg(3'd4, 20'h0);
    rreg(3'd4, v);
    chk("R3 unlocked stop", v[1], 0);

    // R8 address bit 17 on I/O side blocks the pin
    wreg(3'd0, 20'h01000); wreg(3'd1, 20'h20034);
    wreg(3'd2, 20'd3); wreg(3'd3, 20'h0000C);
    wreg(3'd4, 20'h2);
    dreq_n = 1'b0;
    repeat (30) @(negedge clk);
    rreg(3'd2, v);
    chk("R8 gated pin moves nothing", v, 3);
    dreq_n = 1'b1;
    wreg(3'd4, 20'h0);
    // R8 bit 18 is don't-care
    setup(20'h01000, 20'h40034, 2'd0, 2'd3, 3, 0, 0, 0);
    dreq_n = 1'b0;
    wait_done("R8 bit18");
    dreq_n = 1'b1;
    finish_chk("R8 bit18", 0);

    // R9 serial peer, destination I/O uses tx_empty
    dreq_n = 1'b0; rx_full = 1'b1; tx_empty = 1'b0;
    setup(20'h03000, 20'h000F0, 2'd0, 2'd3, 5, 1, 0, 1);
    repeat (30) @(negedge clk);
    chk("R9 pin and rx flag ignored", wr_seen, 0);
    tx_empty = 1'b1;
    wait_done("R9 tx");
    finish_chk("R9 tx", 1);
    // R9 source I/O uses rx_full
    tx_empty = 1'b1; rx_full = 1'b0; dreq_n = 1'b0;
    setup(20'h000E0, 20'h05000, 2'd3, 2'd1, 3, 0, 0, 1);
    repeat (30) @(negedge clk);
    chk("R9 tx flag ignored for source port", wr_seen, 0);
    rx_full = 1'b1;
    wait_done("R9 rx");
    finish_chk("R9 rx", 0);
    rx_full = 1'b0; tx_empty = 1'b0; dreq_n = 1'b1;

    // R12 count zero means full range
    setup(20'h08000, 20'h09000, 2'd0, 2'd0, 0, 1, 0, 0);
    dreq_n = 1'b0;
    wait_done("R12 zero count");
    dreq_n = 1'b1;
    finish_chk("R12 zero count", 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule